// File: doc/BRIEF.md
# Multicycle RISC Instruction Sequencer

This block is a small non-pipelined processor core for a 32-bit load/store instruction set. It holds one instruction at a time and walks it through a short chain of states: a shared fetch state, a shared decode state that reads both source operands, and then a few states that belong to the instruction's class. Register-register and register-immediate arithmetic, loads, stores, conditional branches, jumps, calls and register-indirect jumps each follow their own fixed path through these states. Every path ends back in fetch.

The core uses a single memory port for both instructions and data. The memory must return read data combinationally for the address driven in the same cycle, and it writes on the rising clock edge when the write strobe is high. Inside the core are a 32-entry register file, a six-operation ALU and the internal holding registers: the instruction register, the two operand latches, the result latch and the writeback latch. The current program counter is brought out for debug.

Top module: `mc_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, the PC reads RESET_VEC (default 0), the write strobe is low and the memory address equals the PC.
- R2: Every instruction begins with one fetch cycle. In that cycle the memory address equals the PC and the strobe is low, and the PC then becomes PC+4. All later PC arithmetic uses this incremented value.
- R3: Opcode 0x00 is register-register: rs = bits 25:21, rt = bits 20:16, rd = bits 15:11, function = bits 5:0. The function codes are 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x26 xor and 0x2A signed set-less-than. The result rs op rt is written to rd.
- R4: The register-immediate opcodes are 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or and 0x0E xor. They take rs op sign-extended bits 15:0 and write the result to rt.
- R5: Register 0 reads as zero. A write that targets it is discarded.
- R6: A load (0x23) reads the word at rs + sign-extended immediate into rt. A store (0x2B) writes rt to that same address. Both use the wrapped 32-bit sum, which may be negative-offset.
- R7: Opcode 0x04 branches when rs is zero and opcode 0x05 branches when rs is nonzero. A taken branch sets PC to (PC+4) + (sign-extended immediate << 2). A branch that is not taken leaves PC+4.
- R8: Opcode 0x02 sets PC to {upper 4 bits of PC+4, bits 25:0, 2'b00}.
- R9: Opcode 0x03 writes PC+4 into register 31 and jumps as in R8. Opcode 0x12 sets PC to the value of rs.
- R10: Any other opcode, and any register-register function code not listed in R3, changes no register, PC beyond R2 or memory, and the next fetch follows after the decode cycle.
- R11: Each instruction takes a fixed number of cycles by class: 5 for ALU ops and loads, 4 for stores, 3 for branches, jumps, calls and register jumps, and 2 for undefined encodings.
- R12: The write strobe is high for exactly one cycle per store, in its last cycle, and never for any other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | 32 | Read data for the address driven this cycle |
| mem_addr | output | 32 | Byte address: PC in fetch, computed address in load/store |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe, one cycle per store |
| dbg_pc | output | 32 | Current program counter |

## Verification
The bench uses the default RESET_VEC of zero, which places the first fetch at word 0 of a 1024-word memory model. The address then wraps within that memory, so random jump targets, register-indirect jumps, unaligned register values and stores that overwrite code all stay in a space the reference model mirrors exactly. A directed program first pins down register 0, a skipped branch shadow, a call's link value, an undefined opcode and a negative store displacement. After that, thousands of random instructions are checked, instruction by instruction, against an independent instruction-level model at every fetch and every store.

// File: rtl/mc_core.sv
module mc_core #(
  parameter logic [31:0] RESET_VEC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  output logic [31:0] dbg_pc
);

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_J    = 6'h02;
  localparam logic [5:0] OP_JAL  = 6'h03;
  localparam logic [5:0] OP_BEQZ = 6'h04;
  localparam logic [5:0] OP_BNEZ = 6'h05;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_SLTI = 6'h0A;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_XORI = 6'h0E;
  localparam logic [5:0] OP_JR   = 6'h12;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;
  localparam logic [4:0] LINK    = 5'd31;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_RR, S_RI, S_ADDR, S_LOAD, S_STORE,
    S_SETWB, S_WRITE, S_BR, S_JMP, S_JSR, S_JR
  } state_t;

  state_t      state, dispatch;
  logic [31:0] pc, ir, a, b, r, wb;
  logic [31:0] rf [32];

  wire  [5:0]  op   = ir[31:26];
  wire  [4:0]  rs   = ir[25:21];
  wire  [4:0]  rt   = ir[20:16];
  wire  [4:0]  rd   = ir[15:11];
  wire  [5:0]  fn   = ir[5:0];
  wire  [31:0] simm = {{16{ir[15]}}, ir[15:0]};
  wire  [31:0] jtgt = {pc[31:28], ir[25:0], 2'b00};
  wire  [4:0]  dest = (op == OP_RR) ? rd : rt;

  logic [2:0]  rr_sel, ri_sel;
  logic        rr_ok;

  always_comb begin
    rr_ok = 1'b1;
    case (fn)
      6'h20:   rr_sel = 3'd0;
      6'h22:   rr_sel = 3'd1;
      6'h24:   rr_sel = 3'd2;
      6'h25:   rr_sel = 3'd3;
      6'h26:   rr_sel = 3'd4;
      6'h2A:   rr_sel = 3'd5;
      default: begin rr_sel = 3'd0; rr_ok = 1'b0; end
    endcase
  end

  always_comb begin
    case (op)
      OP_SLTI: ri_sel = 3'd5;
      OP_ANDI: ri_sel = 3'd2;
      OP_ORI:  ri_sel = 3'd3;
      OP_XORI: ri_sel = 3'd4;
      default: ri_sel = 3'd0;
    endcase
  end

  always_comb begin
    case (op)
      OP_RR:                                    dispatch = rr_ok ? S_RR : S_FETCH;
      OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_XORI: dispatch = S_RI;
      OP_LW, OP_SW:                             dispatch = S_ADDR;
      OP_BEQZ, OP_BNEZ:                         dispatch = S_BR;
      OP_J:                                     dispatch = S_JMP;
      OP_JAL:                                   dispatch = S_JSR;
      OP_JR:                                    dispatch = S_JR;
      default:                                  dispatch = S_FETCH;
    endcase
  end

  function automatic logic [31:0] alu(input logic [2:0] f, input logic [31:0] x, input logic [31:0] y);
    case (f)
      3'd0:    return x + y;
      3'd1:    return x - y;
      3'd2:    return x & y;
      3'd3:    return x | y;
      3'd4:    return x ^ y;
      default: return {31'b0, $signed(x) < $signed(y)};
    endcase
  endfunction

  wire br_take = (a == 32'h0) ^ (op == OP_BNEZ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= RESET_VEC;
      ir    <= '0;
      a     <= '0;
      b     <= '0;
      r     <= '0;
      wb    <= '0;
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir    <= mem_rdata;
          pc    <= pc + 32'd4;
          state <= S_DECODE;
        end
        S_DECODE: begin
          a     <= (rs == 5'd0) ? 32'h0 : rf[rs];
          b     <= (rt == 5'd0) ? 32'h0 : rf[rt];
          state <= dispatch;
        end
        S_RR: begin
          r     <= alu(rr_sel, a, b);
          state <= S_SETWB;
        end
        S_RI: begin
          r     <= alu(ri_sel, a, simm);
          state <= S_SETWB;
        end
        S_ADDR: begin
          r     <= a + simm;
          state <= (op == OP_SW) ? S_STORE : S_LOAD;
        end
        S_LOAD: begin
          wb    <= mem_rdata;
          state <= S_WRITE;
        end
        S_STORE: state <= S_FETCH;
        S_SETWB: begin
          wb    <= r;
          state <= S_WRITE;
        end
        S_WRITE: begin
          if (dest != 5'd0) rf[dest] <= wb;
          state <= S_FETCH;
        end
        S_BR: begin
          if (br_take) pc <= pc + {simm[29:0], 2'b00};
          state <= S_FETCH;
        end
        S_JMP: begin
          pc    <= jtgt;
          state <= S_FETCH;
        end
        S_JSR: begin
          rf[LINK] <= pc;
          pc       <= jtgt;
          state    <= S_FETCH;
        end
        S_JR: begin
          pc    <= a;
          state <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  assign mem_addr  = (state == S_LOAD || state == S_STORE) ? r : pc;
  assign mem_wdata = b;
  assign mem_we    = (state == S_STORE);
  assign dbg_pc    = pc;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic [31:0] pc,
  input logic [31:0] x0,
  input logic        is_fetch,
  input logic        is_decode,
  input logic        is_addr,
  input logic        is_quiet
);

  // R12
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  // R12
  store_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> $past(is_addr));

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |=> pc == $past(pc) + 32'd4);

  // R11
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |=> is_decode);

  // R10
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_quiet |=> $stable(pc));

  // R5
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x0 == 32'h0);

endmodule

bind mc_core mc_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .we        (mem_we),
  .pc        (pc),
  .x0        (rf[0]),
  .is_fetch  (state == S_FETCH),
  .is_decode (state == S_DECODE),
  .is_addr   (state == S_ADDR),
  .is_quiet  (state == S_DECODE || state == S_RR || state == S_RI || state == S_ADDR ||
              state == S_LOAD || state == S_STORE || state == S_SETWB || state == S_WRITE)
);

// File: tb/sim_mc_core.sv
module sim_mc_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_rdata, mem_addr, mem_wdata, dbg_pc;
  logic        mem_we;

  logic [31:0] mem  [1024];
  logic [31:0] rmem [1024];
  logic [31:0] rreg [32];
  logic [31:0] rpc;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mc_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .dbg_pc(dbg_pc)
  );

  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] f, input int d, input int s, input int t);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] o, input int t, input int s, input int imm);
    return {o, 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] o, input int tg);
    return {o, 26'(tg)};
  endfunction

  function automatic int pick_reg();
    int k = int'($urandom % 9);
    return (k == 8) ? 31 : k;
  endfunction

  function automatic logic [31:0] gen_instr();
    logic [5:0] rrf [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A};
    logic [5:0] rio [5] = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E};
    int k = int'($urandom % 16);
    int sm = int'($urandom % 9) - 4;
    case (k)
      0, 1, 2, 3: return enc_r(rrf[$urandom % 6], pick_reg(), pick_reg(), pick_reg());
      4, 5, 6:    return enc_i(rio[$urandom % 5], pick_reg(), pick_reg(),
                               ($urandom % 2) ? sm : int'($urandom % 65536));
      7:          return enc_i(6'h23, pick_reg(), pick_reg(), int'($urandom % 65536));
      8:          return enc_i(6'h2B, pick_reg(), pick_reg(), int'($urandom % 65536));
      9:          return enc_i(6'h04, 0, pick_reg(), sm);
      10:         return enc_i(6'h05, 0, pick_reg(), sm);
      11:         return enc_j(6'h02, int'($urandom % 1024));
      12:         return enc_j(6'h03, int'($urandom % 1024));
      13:         return enc_i(6'h12, 0, pick_reg(), 0);
      14:         return enc_r(6'h21, pick_reg(), pick_reg(), pick_reg());
      default:    return $urandom;
    endcase
  endfunction

  function automatic logic [31:0] rdreg(input logic [4:0] n);
    return (n == 5'd0) ? 32'h0 : rreg[n];
  endfunction

  task automatic wrreg(input logic [4:0] n, input logic [31:0] v);
    if (n != 5'd0) rreg[n] = v;
  endtask

  task automatic iss_step(output int ncyc, output bit st, output logic [31:0] sa,
                          output logic [31:0] sd, output string tag);
    logic [31:0] ins = rmem[rpc[11:2]];
    logic [5:0]  op = ins[31:26];
    logic [31:0] x = rdreg(ins[25:21]);
    logic [31:0] y = rdreg(ins[20:16]);
    logic [31:0] im = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] pc4 = rpc + 32'd4;
    logic [31:0] jt = {pc4[31:28], ins[25:0], 2'b00};
    st = 1'b0; sa = '0; sd = '0;
    rpc = pc4;
    case (op)
      6'h00: begin
        tag = "R3"; ncyc = 5;
        case (ins[5:0])
          6'h20: wrreg(ins[15:11], x + y);
          6'h22: wrreg(ins[15:11], x - y);
          6'h24: wrreg(ins[15:11], x & y);
          6'h25: wrreg(ins[15:11], x | y);
          6'h26: wrreg(ins[15:11], x ^ y);
          6'h2A: wrreg(ins[15:11], ($signed(x) < $signed(y)) ? 32'd1 : 32'd0);
          default: begin tag = "R10"; ncyc = 2; end
        endcase
      end
      6'h08: begin tag = "R4"; ncyc = 5; wrreg(ins[20:16], x + im); end
      6'h0A: begin tag = "R4"; ncyc = 5; wrreg(ins[20:16], ($signed(x) < $signed(im)) ? 32'd1 : 32'd0); end
      6'h0C: begin tag = "R4"; ncyc = 5; wrreg(ins[20:16], x & im); end
      6'h0D: begin tag = "R4"; ncyc = 5; wrreg(ins[20:16], x | im); end
      6'h0E: begin tag = "R4"; ncyc = 5; wrreg(ins[20:16], x ^ im); end
      6'h23: begin tag = "R6"; ncyc = 5; wrreg(ins[20:16], rmem[(x + im) >> 2 & 32'h3FF]); end
      6'h2B: begin
        tag = "R6"; ncyc = 4; st = 1'b1; sa = x + im; sd = y;
        rmem[sa[11:2]] = y;
      end
      6'h04: begin tag = "R7"; ncyc = 3; if (x == 0) rpc = pc4 + (im << 2); end
      6'h05: begin tag = "R7"; ncyc = 3; if (x != 0) rpc = pc4 + (im << 2); end
      6'h02: begin tag = "R8"; ncyc = 3; rpc = jt; end
      6'h03: begin tag = "R9"; ncyc = 3; wrreg(5'd31, pc4); rpc = jt; end
      6'h12: begin tag = "R9"; ncyc = 3; rpc = x; end
      default: begin tag = "R10"; ncyc = 2; end
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    foreach (rreg[i]) rreg[i] = '0;
    rpc = 32'h0;
    repeat (3) @(negedge clk);
    chk(dbg_pc == 32'h0, "R1 reset pc", dbg_pc, 32'h0);
    chk(mem_we == 1'b0, "R1 reset strobe", {31'b0, mem_we}, 32'h0);
    rst_n = 1'b1;
    #1;
    chk(mem_addr == 32'h0, "R1 first fetch address", mem_addr, 32'h0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      int ncyc, nwe;
      bit st;
      logic [31:0] sa, sd;
      string tag, ptag;
      ptag = (i == 0) ? "R1" : tag;
      chk(dbg_pc == rpc, {"R11 pc at fetch after ", ptag}, dbg_pc, rpc);
      chk(mem_addr == rpc, "R2 fetch address", mem_addr, rpc);
      iss_step(ncyc, st, sa, sd, tag);
      nwe = 0;
      for (int k = 0; k < ncyc; k++) begin
        if (mem_we) begin
          nwe++;
          chk(st && k == ncyc - 1, "R12 strobe placement", k, ncyc - 1);
          chk(mem_addr == sa, "R6 store address", mem_addr, sa);
          chk(mem_wdata == sd, "R6 store data", mem_wdata, sd);
        end
        @(negedge clk);
      end
      chk(nwe == (st ? 1 : 0), "R12 strobe count", nwe, st ? 1 : 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    foreach (mem[i]) mem[i] = '0;
    mem[32'h00 >> 2] = enc_i(6'h08, 1, 0, 5);
    mem[32'h04 >> 2] = enc_i(6'h08, 2, 0, -3);
    mem[32'h08 >> 2] = enc_r(6'h20, 3, 1, 2);
    mem[32'h0C >> 2] = enc_i(6'h2B, 3, 0, 32'h100);
    mem[32'h10 >> 2] = enc_r(6'h2A, 4, 2, 1);
    mem[32'h14 >> 2] = enc_i(6'h2B, 4, 0, 32'h104);
    mem[32'h18 >> 2] = enc_i(6'h08, 0, 0, 9);
    mem[32'h1C >> 2] = enc_i(6'h2B, 0, 0, 32'h108);
    mem[32'h20 >> 2] = enc_i(6'h23, 5, 0, 32'h100);
    mem[32'h24 >> 2] = enc_i(6'h08, 5, 5, -2);
    mem[32'h28 >> 2] = enc_i(6'h04, 0, 5, 1);
    mem[32'h2C >> 2] = enc_i(6'h2B, 1, 0, 32'h10C);
    mem[32'h30 >> 2] = enc_j(6'h03, 32'h40 >> 2);
    mem[32'h40 >> 2] = enc_i(6'h2B, 31, 0, 32'h110);
    mem[32'h44 >> 2] = 32'hFC00_0000;
    mem[32'h48 >> 2] = enc_i(6'h08, 6, 0, 32'h50);
    mem[32'h4C >> 2] = enc_i(6'h12, 0, 6, 0);
    mem[32'h50 >> 2] = enc_r(6'h22, 7, 2, 1);
    mem[32'h54 >> 2] = enc_i(6'h2B, 7, 6, -4);
    mem[32'h58 >> 2] = enc_i(6'h05, 0, 0, -1);
    mem[32'h5C >> 2] = enc_j(6'h02, 32'h5C >> 2);
    foreach (mem[i]) rmem[i] = mem[i];
    do_reset();
    run(24);
    chk(mem[32'h100 >> 2] == 32'd2, "R3 add result", mem[32'h100 >> 2], 32'd2);
    chk(mem[32'h104 >> 2] == 32'd1, "R3 signed slt", mem[32'h104 >> 2], 32'd1);
    chk(mem[32'h108 >> 2] == 32'd0, "R5 register zero", mem[32'h108 >> 2], 32'd0);
    chk(mem[32'h10C >> 2] == 32'd0, "R7 taken branch skips", mem[32'h10C >> 2], 32'd0);
    chk(mem[32'h110 >> 2] == 32'h34, "R9 link value", mem[32'h110 >> 2], 32'h34);
    chk(mem[32'h4C >> 2] == 32'hFFFF_FFF8, "R6 negative displacement", mem[32'h4C >> 2], 32'hFFFF_FFF8);
    chk(dbg_pc == 32'h5C, "R8 jump to self", dbg_pc, 32'h5C);

    foreach (mem[i]) begin
      mem[i]  = gen_instr();
      rmem[i] = mem[i];
    end
    do_reset();
    run(4000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule